// File: doc/BRIEF.md
# Three-Wire Radio Register Loader

This block writes configuration words into an external radio transceiver through a three-wire serial path: a serial clock, a serial data line and a latch strobe. A command names a word of three or four bytes. The block clocks that word out, most significant byte first and most significant bit first within each byte. Once every bit has gone out it raises the latch strobe to commit the word. The length of the serial clock phases comes from a programmable half-period given in system clock cycles.

The loader also keeps the transceiver's fixed configuration words. One command runs the whole start-up sequence. It raises chip-enable and then writes the three configuration registers, and the third register goes out twice: first in its transmit-on form, then in its transmit-off form. Two more commands key the transmitter on and off. Each of them writes the matching stored form of the power register, so a host can send on-off keyed symbols with single commands. A one-cycle done strobe marks the end of every command.

Top module: `radio_reg_loader`

## Requirements
- R1: After reset, busy, done, ser_clk, ser_data, ser_latch and chip_en are all 0. Whenever busy is 0, ser_clk and ser_latch are 0.
- R2: A raw command (cmd_op = 0) with cmd_nbytes equal to N, where N is 3 or 4, sends the low 8*N bits of cmd_word. Bits go out from bit 8*N-1 down to bit 0. The receiver samples each bit on the rising edge of ser_clk. ser_data changes only while ser_clk is low.
- R3: For each bit, ser_clk stays low for exactly H system cycles and then high for exactly H cycles, where H is half_period as sampled when the command is accepted. A half_period of 0 behaves as 1.
- R4: After the last bit of a word, ser_clk returns low. ser_latch then goes high for exactly 2*H cycles while ser_clk stays low, and then falls.
- R5: done is high for exactly one cycle, in the cycle after ser_latch falls for the last word of a command. busy is high from the cycle after acceptance until the cycle that done is high, and it is low in that cycle.
- R6: A command presented while busy is 1 is ignored: no extra word is sent and no extra done pulse occurs.
- R7: A raw command whose cmd_nbytes is not 3 or 4 is ignored: busy stays 0, nothing is shifted and no done pulse occurs.
- R8: cmd_op = 2 (key on) sends the 4-byte word 0x800F7ED2. cmd_op = 1 (key off) sends the 4-byte word 0x800F00D2.
- R9: cmd_op = 3 (start-up) sets chip_en to 1 before the first serial clock edge. chip_en then stays 1 until reset. The command sends 0x713933A0 (4 bytes), 0x029011 (3 bytes), 0x800F7ED2 (4 bytes) and 0x800F00D2 (4 bytes), in that order, each followed by its own latch pulse, and gives a single done pulse after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | DIV_W | Serial clock half-period in cycles (0 acts as 1) |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_op | input | 2 | 0 raw, 1 key off, 2 key on, 3 start-up |
| cmd_word | input | 32 | Raw word, right-aligned |
| cmd_nbytes | input | 3 | Raw word length in bytes (3 or 4) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| ser_clk | output | 1 | Serial clock to the radio |
| ser_data | output | 1 | Serial data to the radio |
| ser_latch | output | 1 | Latch strobe committing a shifted word |
| chip_en | output | 1 | Radio chip enable |

## Verification
A wrong bit index or a wrong shift state appears as a wrong word at the next latch fall. It can be seen within one word, at most about 64*H cycles. A miscounted divider shows up on the first clock phase, and a miscounted latch shows up when the latch falls. Both are measured against H in every run. A sequencing fault in the start-up command appears as a missing, extra or reordered word, or as a done strobe that arrives before the fourth latch.

// File: rtl/radio_ldr_pkg.sv
package radio_ldr_pkg;
  localparam int WORD_W = 32;
  localparam int NB_W   = 3;
  localparam int BIDX_W = $clog2(WORD_W);

  typedef enum logic [1:0] {
    OP_RAW     = 2'd0,
    OP_KEY_OFF = 2'd1,
    OP_KEY_ON  = 2'd2,
    OP_INIT    = 2'd3
  } op_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [NB_W-1:0]   nbytes;
  } reg_word_t;

  // stored selector: 0 synth, 1 clocking, 2 power low, 3 power high
  function automatic reg_word_t stored_word(input logic [1:0] sel);
    reg_word_t r;
    case (sel)
      2'd0:    r = '{word: 32'h7139_33A0, nbytes: 3'd4};
      2'd1:    r = '{word: 32'h0002_9011, nbytes: 3'd3};
      2'd2:    r = '{word: 32'h800F_00D2, nbytes: 3'd4};
      default: r = '{word: 32'h800F_7ED2, nbytes: 3'd4};
    endcase
    return r;
  endfunction

  // start-up order: synth, clocking, power high, power low
  function automatic logic [1:0] init_sel(input logic [1:0] step);
    case (step)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      2'd2:    return 2'd3;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/radio_word_select.sv
module radio_word_select
  import radio_ldr_pkg::*;
(
  input  op_e                op,
  input  logic [1:0]         step,
  input  logic [WORD_W-1:0]  raw_word,
  input  logic [NB_W-1:0]    raw_nbytes,
  output reg_word_t          sel_word
);
  always_comb begin
    case (op)
      OP_RAW:     sel_word = '{word: raw_word, nbytes: raw_nbytes};
      OP_KEY_OFF: sel_word = stored_word(2'd2);
      OP_KEY_ON:  sel_word = stored_word(2'd3);
      default:    sel_word = stored_word(init_sel(step));
    endcase
  end
endmodule

// File: rtl/radio_bit_shifter.sv
module radio_bit_shifter
  import radio_ldr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  reg_word_t         in_word,
  input  logic [DIV_W-1:0]  hp,
  output logic              sclk,
  output logic              sdata,
  output logic              slatch,
  output logic              word_done,
  output logic              active
);
  localparam int CNT_W = DIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_LATCH} st_e;
  st_e                st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BIDX_W-1:0]  bit_q;
  logic [WORD_W-1:0]  word_q;

  logic [CNT_W-1:0]   half_m1, latch_m1;
  logic [BIDX_W-1:0]  first_bit;
  assign half_m1   = {1'b0, hp} - 1'b1;
  assign latch_m1  = {hp, 1'b0} - 1'b1;
  assign first_bit = BIDX_W'({in_word.nbytes, 3'b000} - 1'b1);
  assign active    = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      word_q    <= '0;
      sclk      <= 1'b0;
      sdata     <= 1'b0;
      slatch    <= 1'b0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          word_q <= in_word.word;
          bit_q  <= first_bit;
          sdata  <= in_word.word[first_bit];
          sclk   <= 1'b0;
          cnt_q  <= half_m1;
          st_q   <= S_LOW;
        end
        S_LOW: if (cnt_q == '0) begin
          sclk  <= 1'b1;
          cnt_q <= half_m1;
          st_q  <= S_HIGH;
        end else cnt_q <= cnt_q - 1'b1;
        S_HIGH: if (cnt_q == '0) begin
          sclk <= 1'b0;
          if (bit_q == '0) begin
            slatch <= 1'b1;
            cnt_q  <= latch_m1;
            st_q   <= S_LATCH;
          end else begin
            bit_q <= bit_q - 1'b1;
            sdata <= word_q[bit_q - 1'b1];
            cnt_q <= half_m1;
            st_q  <= S_LOW;
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) begin
          slatch    <= 1'b0;
          word_done <= 1'b1;
          st_q      <= S_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/radio_reg_loader.sv
module radio_reg_loader
  import radio_ldr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [31:0]       cmd_word,
  input  logic [2:0]        cmd_nbytes,
  output logic              busy,
  output logic              done,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_latch,
  output logic              chip_en
);
  op_e               op_q;
  logic [1:0]        step_q;
  logic [WORD_W-1:0] raw_q;
  logic [NB_W-1:0]   rawn_q;
  logic [DIV_W-1:0]  hp_q;
  logic              pend_q;
  logic              accept, len_ok, word_done, sh_active;
  logic [1:0]        last_step;
  reg_word_t         cur_word;

  assign len_ok    = (cmd_nbytes == 3'd3) || (cmd_nbytes == 3'd4);
  assign accept    = cmd_valid && !busy && (op_e'(cmd_op) != OP_RAW || len_ok);
  assign last_step = (op_q == OP_INIT) ? 2'd3 : 2'd0;

  radio_word_select u_sel (
    .op(op_q), .step(step_q), .raw_word(raw_q), .raw_nbytes(rawn_q),
    .sel_word(cur_word)
  );

  radio_bit_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .start(pend_q), .in_word(cur_word), .hp(hp_q),
    .sclk(ser_clk), .sdata(ser_data), .slatch(ser_latch),
    .word_done(word_done), .active(sh_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      chip_en <= 1'b0;
      pend_q  <= 1'b0;
      op_q    <= OP_RAW;
      step_q  <= '0;
      raw_q   <= '0;
      rawn_q  <= '0;
      hp_q    <= DIV_W'(1);
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        pend_q <= 1'b1;
        op_q   <= op_e'(cmd_op);
        step_q <= '0;
        raw_q  <= cmd_word;
        rawn_q <= cmd_nbytes;
        hp_q   <= (half_period == '0) ? DIV_W'(1) : half_period;
        if (op_e'(cmd_op) == OP_INIT) chip_en <= 1'b1;
      end else if (pend_q && !sh_active) begin
        pend_q <= 1'b0;
      end
      if (word_done) begin
        if (step_q == last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
          pend_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/radio_reg_loader_chk.sv
module radio_reg_loader_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_latch,
  input logic chip_en
);
  // R2: data holds while the serial clock stays high
  a_r2_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  // R4: latch only while serial clock is low
  a_r4_latch_clk_low: assert property (@(posedge clk) disable iff (rst)
    ser_latch |-> !ser_clk);
  // R5: done lasts one cycle and coincides with busy low
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R1: quiet lines when idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_latch));
  // R9: chip enable never drops
  a_r9_chip_en_hold: assert property (@(posedge clk) disable iff (rst)
    $past(chip_en) |-> chip_en);
endmodule

bind radio_reg_loader radio_reg_loader_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ser_clk(ser_clk),
  .ser_data(ser_data), .ser_latch(ser_latch), .chip_en(chip_en)
);

// File: tb/radio_reg_loader_tb_top.sv
module radio_reg_loader_tb_top;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] half_period = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_word = '0;
  logic [2:0] cmd_nbytes = '0;
  logic busy, done, ser_clk, ser_data, ser_latch, chip_en;

  always #2.5 clk = ~clk;

  radio_reg_loader #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .half_period(half_period), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_word(cmd_word), .cmd_nbytes(cmd_nbytes),
    .busy(busy), .done(done), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .chip_en(chip_en)
  );

  int tests = 0, fails = 0;
  int cyc = 0, exp_hp = 1;
  int hi_run = 0, lo_run = 0, le_run = 0, ncap = 0, lf_cyc = -10;
  int nwords = 0, done_cnt = 0, terr = 0, busy_seen = 0;
  logic prev_clk = 1'b0, prev_le = 1'b0;
  logic [31:0] cap = '0;
  logic [31:0] got_w [0:7];
  int got_n [0:7];
  logic [31:0] ew [0:3];
  int en [0:3];
  int enw = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor samples away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (busy) busy_seen++;
    if (ser_clk) hi_run++;
    else begin
      lo_run++;
      if (prev_clk) begin
        if (hi_run != exp_hp) terr++;
        hi_run = 0;
      end
    end
    if (ser_clk && !prev_clk) begin
      if (ncap > 0 && lo_run != exp_hp) terr++;
      cap = {cap[30:0], ser_data};
      ncap++;
      lo_run = 0;
    end
    if (ser_latch) begin
      le_run++;
      if (ser_clk) terr++;
    end else if (prev_le) begin
      if (le_run != 2 * exp_hp) terr++;
      if (nwords < 8) begin got_w[nwords] = cap; got_n[nwords] = ncap; end
      nwords++;
      cap = '0; ncap = 0; le_run = 0; lo_run = 0; lf_cyc = cyc;
    end
    if (done) begin
      done_cnt++;
      if (cyc != lf_cyc + 1) terr++;
      if (busy) terr++;
    end
    if (!busy && (ser_clk || ser_latch)) terr++;
    prev_clk = ser_clk;
    prev_le  = ser_latch;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic clear_mon();
    nwords = 0; done_cnt = 0; terr = 0; busy_seen = 0;
  endtask

  // issue one command; poke>0 re-presents a different command mid-run
  task automatic issue(input int op, input logic [31:0] w, input int nb,
                       input int hp, input int poke);
    @(negedge clk);
    clear_mon();
    exp_hp = (hp == 0) ? 1 : hp;
    half_period = DIV_W'(hp);
    cmd_op = op[1:0]; cmd_word = w; cmd_nbytes = nb[2:0];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 5000 && done_cnt == 0; i++) begin
      if (poke > 0 && i == poke) begin
        cmd_op = 2'd0; cmd_word = ~w; cmd_nbytes = 3'd4; cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic verify(input string req);
    chk(done_cnt == 1, req, "done count", done_cnt, 1);
    chk(terr == 0, "R3/R4/R5", {req, " timing"}, terr, 0);
    chk(nwords == enw, req, "word count", nwords, enw);
    for (int k = 0; k < enw && k < nwords; k++) begin
      chk(got_w[k] == ew[k], req, "word value", got_w[k], ew[k]);
      chk(got_n[k] == 8 * en[k], req, "bit count", got_n[k], 8 * en[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, ser_clk, ser_data, ser_latch, chip_en} == 6'b0,
        "R1", "reset outputs", {busy, done, ser_clk, ser_data, ser_latch, chip_en}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5: raw sweep over half-periods and lengths
    for (int hp = 0; hp <= 4; hp++) begin
      for (int nb = 3; nb <= 4; nb++) begin
        for (int p = 0; p < 3; p++) begin
          logic [31:0] w;
          w = 32'hA5C3_0F96 ^ (32'h1357_9BDF * (hp * 7 + nb * 3 + p));
          issue(0, w, nb, hp, 0);
          enw = 1; en[0] = nb;
          ew[0] = (nb == 3) ? {8'h00, w[23:0]} : w;
          verify("R2");
        end
      end
    end

    // R8 key on / key off
    issue(2, 32'h0, 0, 2, 0);
    enw = 1; en[0] = 4; ew[0] = 32'h800F7ED2;
    verify("R8");
    issue(1, 32'h0, 0, 3, 0);
    enw = 1; en[0] = 4; ew[0] = 32'h800F00D2;
    verify("R8");

    // R6 command while busy is ignored
    issue(0, 32'h00C0FFEE, 3, 2, 6);
    enw = 1; en[0] = 3; ew[0] = 32'h00C0FFEE;
    verify("R6");

    // R7 invalid lengths ignored
    for (int nb = 0; nb < 8; nb++) begin
      if (nb == 3 || nb == 4) continue;
      @(negedge clk);
      clear_mon();
      cmd_op = 2'd0; cmd_word = 32'hFFFF_FFFF; cmd_nbytes = nb[2:0];
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (40) @(negedge clk);
      chk(busy_seen == 0 && nwords == 0 && done_cnt == 0, "R7",
          "refused length activity", busy_seen + nwords + done_cnt, 0);
    end

    // R9 start-up sequence
    chk(chip_en == 1'b0, "R9", "chip_en before start-up", chip_en, 0);
    @(negedge clk);
    clear_mon();
    exp_hp = 2; half_period = 8'd2; cmd_op = 2'd3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(chip_en == 1'b1 && ser_clk == 1'b0, "R9", "chip_en before first edge", chip_en, 1);
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    enw = 4;
    ew[0] = 32'h713933A0; en[0] = 4;
    ew[1] = 32'h00029011; en[1] = 3;
    ew[2] = 32'h800F7ED2; en[2] = 4;
    ew[3] = 32'h800F00D2; en[3] = 4;
    verify("R9");
    issue(2, 32'h0, 0, 1, 0);
    chk(chip_en == 1'b1, "R9", "chip_en stays high", chip_en, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule